// File: doc/BRIEF.md
# SD Host Interrupt Status Aggregator

This block gathers single-cycle event pulses from the command engine, data engine, FIFO, SDIO and card-detect logic of an SD host controller into one sticky status word. Software reads the word in two views: the raw view, which shows every captured event, and the masked view, which shows only the events that a mask register selects. Software acknowledges events by writing ones to the raw view. Bits written as zero are left as they are.

A single interrupt line goes high when at least one masked bit is pending and the global interrupt enable in the control word is on. The line comes from a register, so it rises one cycle after the status bit that qualifies it. Two further outputs summarise the raw word. One is an error flag, which is the OR of every error event. The other is a completion flag, which is the OR of every done event. The register interface is a simple single-cycle write strobe with a combinational read port.

Top module: `sdh_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, the raw status, mask, masked status, global enable and `irq_o` all read 0.
- R2: A pulse on `evt_i[n]` sets raw status bit n at the next clock edge. The bit stays set with no further pulse until software clears it.
- R3: A write to offset 0x38 clears every raw bit whose write-data bit is 1. Raw bits whose write-data bit is 0 keep their value.
- R4: When an event pulse and a clearing write reach the same raw bit in the same cycle, the bit is set after that edge.
- R5: Offset 0x34 reads the raw status ANDed with the mask, bit for bit. Writes to 0x34 change neither the mask nor the raw status.
- R6: Offset 0x30 holds a 32-bit mask that software can read and write.
- R7: With the global enable on, `irq_o` goes high one cycle after the first masked bit becomes pending. It falls one cycle after the last masked bit clears.
- R8: `irq_o` stays low while the global enable is off, even with masked bits pending. It also stays low while no masked bit is pending.
- R9: `err_sum_o` is the OR of raw bits 1, 6, 7, 8, 9, 11, 12, 13 and 15. These are the response error, response CRC, data CRC, response timeout, data timeout, FIFO run, hardware locked, start bit and end bit events.
- R10: `done_sum_o` is the OR of raw bits 2, 3, 10 and 14. These are the command done, data over, voltage switch done and auto command done events.
- R11: Writing 0xFFFFFFFF to offset 0x38 clears every pending raw bit.
- R12: The global enable is bit 4 of offset 0x00. A read of 0x00 returns that bit and zeros elsewhere, and an unmapped offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | Single-cycle event pulses, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset for the read and write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data at `addr_i` |
| irq_o | output | 1 | Registered interrupt request |
| err_sum_o | output | 1 | OR of the error events in raw status |
| done_sum_o | output | 1 | OR of the done events in raw status |

## Verification
The assertions take the event inputs as edge-sampled levels. The sticky-bit properties count a pulse held for several cycles as a new event on every edge, so they ask only that a clear without an event lands. The bench pulses each event for exactly one cycle, and it performs every register write as a one-cycle strobe between two falling edges. The one deliberate overlap of a clear and an event is the directed R4 case, which makes the event-priority property the one that decides the result.

// File: rtl/sdh_irq_pkg.sv
// Package: offsets, enable bit position and event group masks for the
// interrupt aggregator. Assumes a 32-bit status word and byte offsets.
package sdh_irq_pkg;

    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_MASK   = 'h30;
    localparam int OFS_MASKED = 'h34;
    localparam int OFS_RAW    = 'h38;

    localparam int CTRL_IE_BIT = 4;

    localparam logic [31:0] ERR_GROUP = (32'h1 << 1)  | (32'h1 << 6)  |
                                        (32'h1 << 7)  | (32'h1 << 8)  |
                                        (32'h1 << 9)  | (32'h1 << 11) |
                                        (32'h1 << 12) | (32'h1 << 13) |
                                        (32'h1 << 15);

    localparam logic [31:0] DONE_GROUP = (32'h1 << 2) | (32'h1 << 3) |
                                         (32'h1 << 10) | (32'h1 << 14);

endpackage

// File: rtl/sdh_irq_cfg.sv
// Configuration registers: holds the interrupt mask and the global
// interrupt enable. Assumes a single-cycle write strobe and byte offsets.
module sdh_irq_cfg
    import sdh_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] mask_o,
    output logic              ie_o
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

    logic wr_mask;
    logic wr_ctrl;

    assign wr_mask = wr_en_i && (addr_i == A_MASK);
    assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);

    // Mask register load.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_o <= '0;
        else if (wr_mask) mask_o <= wr_data_i;
    end

    // Global enable bit load.
    always_ff @(posedge clk) begin
        if (!rst_n)       ie_o <= 1'b0;
        else if (wr_ctrl) ie_o <= wr_data_i[CTRL_IE_BIT];
    end

    // R6: a mask write shows up in the register on the next cycle
    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_o == $past(wr_data_i)));

    // R12: enable changes only through a control write
    assert_ie_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ie_o));

endmodule

// File: rtl/sdh_irq_sticky.sv
// Raw status store: one sticky cell per event. A write-one-to-clear on the
// raw offset drops bits, and an event in the same cycle wins. Assumes the
// events are single-cycle pulses that are sampled on the rising edge.
module sdh_irq_sticky
    import sdh_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] raw_o
);

    localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(OFS_RAW);

    logic [DATA_W-1:0] clr_vec;

    // Clear vector, non-zero only on a write to the raw offset.
    always_comb begin
        clr_vec = '0;
        if (wr_en_i && (addr_i == A_RAW)) clr_vec = wr_data_i;
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_cell
        // Sticky bit: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        raw_o[b] <= 1'b0;
            else if (evt_i[b]) raw_o[b] <= 1'b1;
            else if (clr_vec[b]) raw_o[b] <= 1'b0;
        end

        // R2: an event leaves the bit set
        assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[b] |=> raw_o[b]);

        // R2: without event or clear the bit holds
        assert_bit_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_i[b] && !clr_vec[b]) |=> $stable(raw_o[b]));

        // R3: a clear with no event drops the bit
        assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[b] && !evt_i[b]) |=> !raw_o[b]);

        // R4: clear and event together keep the bit set
        assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[b] && evt_i[b]) |=> raw_o[b]);
    end

endmodule

// File: rtl/sdh_irq_out.sv
// Output stage: masked view, registered interrupt line and the error and
// done summaries taken from raw status. Assumes the raw and mask inputs
// come from registers.
module sdh_irq_out
    import sdh_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] raw_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic              ie_i,
    output logic [DATA_W-1:0] masked_o,
    output logic              irq_o,
    output logic              err_o,
    output logic              done_o
);

    localparam logic [DATA_W-1:0] ERR_M  = DATA_W'(ERR_GROUP);
    localparam logic [DATA_W-1:0] DONE_M = DATA_W'(DONE_GROUP);

    logic pending;

    // Masked view and group summaries.
    always_comb begin
        masked_o = raw_i & mask_i;
        pending  = |masked_o;
        err_o    = |(raw_i & ERR_M);
        done_o   = |(raw_i & DONE_M);
    end

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pending && ie_i;
    end

    // R8: a high request needs the enable on in the cycle before
    assert_irq_needs_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ie_i));

    // R7: a high request needs the raw word and the mask to overlap in the cycle before
    assert_irq_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(raw_i & mask_i) != '0));

    // R5: the masked view never shows a bit that is absent from raw
    assert_masked_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_o & ~raw_i) == '0);

endmodule

// File: rtl/sdh_irq_agg.sv
// Top: interrupt aggregation for an SD host. Connects the configuration
// registers, the sticky raw store and the output stage, and drives the
// read mux. Assumes a single-cycle write strobe and a combinational read.
module sdh_irq_agg
    import sdh_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic              err_sum_o,
    output logic              done_sum_o
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);

    logic [DATA_W-1:0] mask_q;
    logic              ie_q;
    logic [DATA_W-1:0] raw_q;
    logic [DATA_W-1:0] masked;

    sdh_irq_cfg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .mask_o    (mask_q),
        .ie_o      (ie_q)
    );

    sdh_irq_sticky #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .raw_o     (raw_q)
    );

    sdh_irq_out #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (raw_q),
        .mask_i   (mask_q),
        .ie_i     (ie_q),
        .masked_o (masked),
        .irq_o    (irq_o),
        .err_o    (err_sum_o),
        .done_o   (done_sum_o)
    );

    // Read mux over the four mapped offsets.
    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            A_CTRL:   rd_data_o[CTRL_IE_BIT] = ie_q;
            A_MASK:   rd_data_o = mask_q;
            A_MASKED: rd_data_o = masked;
            A_RAW:    rd_data_o = raw_q;
            default:  rd_data_o = '0;
        endcase
    end

    // R5: a write to the masked offset leaves the mask unchanged
    assert_masked_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_MASKED) |=> $stable(mask_q));

    // R1: the request is low in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> !irq_o);

endmodule

// File: tb/test_sdh_irq_agg.sv
module test_sdh_irq_agg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, err_s, done_s;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    sdh_irq_agg i_sdh_irq_agg (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
        .irq_o(irq), .err_sum_o(err_s), .done_sum_o(done_s)
    );

    typedef struct packed {
        logic [31:0] ev;
        logic [31:0] mask;
        logic        en;
        logic [31:0] raw;
        logic [31:0] msk;
        logic        err;
        logic        done;
        logic        irq;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0008, 32'hFFFF_FFFF, 1'b1, 32'h0000_0008, 32'h0000_0008, 1'b0, 1'b1, 1'b1},
        '{32'h0000_0080, 32'h0000_0008, 1'b1, 32'h0000_0080, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
        '{32'h0001_0000, 32'h0001_0000, 1'b0, 32'h0001_0000, 32'h0001_0000, 1'b0, 1'b0, 1'b0},
        '{32'hC000_0000, 32'h4000_0000, 1'b1, 32'hC000_0000, 32'h4000_0000, 1'b0, 1'b0, 1'b1},
        '{32'h0000_4A00, 32'h0000_0200, 1'b1, 32'h0000_4A00, 32'h0000_0200, 1'b1, 1'b1, 1'b1},
        '{32'h0000_0030, 32'h0000_0000, 1'b1, 32'h0000_0030, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
        '{32'h0000_0406, 32'h0000_0004, 1'b0, 32'h0000_0406, 32'h0000_0004, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(8'h38, v); chk("R1 raw", v, 32'h0);
        rd(8'h30, v); chk("R1 mask", v, 32'h0);
        rd(8'h34, v); chk("R1 masked", v, 32'h0);
        rd(8'h00, v); chk("R1 enable", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // Table walk: R2 R5 R6 R7 R8 R9 R10
        for (int k = 0; k < NV; k++) begin
            wr(8'h38, 32'hFFFF_FFFF);
            wr(8'h30, VECS[k].mask);
            wr(8'h00, {27'b0, VECS[k].en, 4'b0});
            pulse(VECS[k].ev);
            @(negedge clk);
            rd(8'h38, v); chk("R2 raw sticky", v, VECS[k].raw);
            rd(8'h34, v); chk("R5 masked view", v, VECS[k].msk);
            rd(8'h30, v); chk("R6 mask readback", v, VECS[k].mask);
            chk("R9 error summary", {31'b0, err_s}, {31'b0, VECS[k].err});
            chk("R10 done summary", {31'b0, done_s}, {31'b0, VECS[k].done});
            chk("R7 R8 irq", {31'b0, irq}, {31'b0, VECS[k].irq});
        end

        // R11: all-ones clear
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h38, v); chk("R11 clear all", v, 32'h0);

        // R3: partial clear
        pulse(32'h0000_0088);
        wr(8'h38, 32'h0000_0008);
        rd(8'h38, v); chk("R3 partial clear", v, 32'h0000_0080);

        // R4: event and clear in the same cycle
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h38; wdata = 32'h0000_0088; evt = 32'h0000_0008;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; evt = '0;
        rd(8'h38, v); chk("R4 event wins", v, 32'h0000_0008);

        // R5: write to masked offset ignored
        wr(8'h30, 32'h0000_00F0);
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h30, v); chk("R5 mask untouched", v, 32'h0000_00F0);
        rd(8'h38, v); chk("R5 raw untouched", v, 32'h0000_0008);

        // R7: irq timing
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h30, 32'h0000_0020);
        wr(8'h00, 32'h0000_0010);
        @(negedge clk);
        chk("R7 irq idle", {31'b0, irq}, 32'h0);
        pulse(32'h0000_0020);
        chk("R7 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq one cycle later", {31'b0, irq}, 32'h1);
        wr(8'h38, 32'h0000_0020);
        chk("R7 irq still high in clear cycle", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R7 irq falls", {31'b0, irq}, 32'h0);

        // R8: enable off blocks pending bit
        pulse(32'h0000_0020);
        wr(8'h00, 32'h0000_0000);
        @(negedge clk);
        chk("R8 irq gated", {31'b0, irq}, 32'h0);

        // R12: control read-back and unmapped offset
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R12 ctrl bit4 only", v, 32'h0000_0010);
        rd(8'h3C, v); chk("R12 unmapped", v, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule